// File: doc/BRIEF.md
# Striped ECC Drive Controller

This block sits between a 64-bit I/O bus and an array of single-bit drive lanes. A chunk arrives with one even-parity bit for each byte. The block checks that parity, then splits the chunk into a low word and a high word of 32 bits each. It protects each word with a 39-bit SEC-DED codeword: six Hamming check bits plus one overall parity bit. Each codeword bit goes out on its own lane. If a whole drive dies, every stored word therefore loses at most one bit, and the code repairs that bit on read.

Forty-two physical lanes exist: 39 for the codeword and three spares. A map register assigns each codeword position to a physical lane. A lane can be marked failed, after which its read value is treated as zero. Moving a position onto a spare lane and reading with rebuild enabled returns the corrected bit and the spare lane it belongs to. The surrounding logic can then write that bit onto the new drive.

A four-state controller sequences the work.
- `S_IDLE` accepts requests. A write with good parity takes the `IDLE→WR_LO` transition. A read, when no write is requested, takes `IDLE→RD`. A write with bad parity, and any idle cycle without a request, takes `IDLE→IDLE`.
- `S_WR_LO` drives the codeword of the low word and always moves on (`WR_LO→WR_HI`).
- `S_WR_HI` drives the codeword of the high word and returns (`WR_HI→IDLE`).
- `S_RD` presents the decoded word for one cycle and returns (`RD→IDLE`).

Top module: `stripe_ecc_ctrl`

## Requirements
- R1: `wr_par[b]` must equal the XOR of bits `8b+7..8b` of `wr_chunk`. If any byte mismatches, the chunk is dropped: `par_err` is 1 in the cycle after the request, and `lane_wr_valid` and `busy` stay 0.
- R2: A chunk with good parity gives `lane_wr_valid=1` and `busy=1` for exactly two cycles, starting the cycle after the request. The first cycle carries the codeword of `wr_chunk[31:0]` and the second the codeword of `wr_chunk[63:32]`. After reset `busy`, `lane_wr_valid`, `par_err` and `rd_out_valid` are 0.
- R3: Codeword layout. Index 0 is even parity over all 39 bits. Indices 1, 2, 4, 8, 16 and 32 are check bits: the bit at 2^k is the XOR of all other indices 1..38 whose index has bit k set. The 32 data bits fill the remaining indices in ascending order, so data bit 0 is at index 3.
- R4: After reset, codeword index p maps to lane p, and spare lanes 39..41 are driven 0 on writes. A pulse on `map_we` moves index `map_pos` to lane `map_lane`. A map write with `map_lane` ≥ 42 is ignored.
- R5: A read request in idle gives `rd_out_valid=1` for one cycle, one cycle later, with `rd_data` decoded from `lane_rd_bits` through the map. For a clean codeword `rd_fix=0` and `rd_bad=0`.
- R6: A single flipped bit at any codeword index, including the check bits and index 0, is corrected, and `rd_fix=1`.
- R7: Two flipped bits give `rd_bad=1`, `rd_fix=0` and `rd_data=0`.
- R8: A lane marked failed (`fail_we` with `fail_val=1`) reads as 0 whatever is driven on it. With one failed lane the data is still returned correctly.
- R9: With `rb_en=1` a read also gives `rb_valid=1`, `rb_lane` = the lane mapped to `rb_pos`, and `rb_bit` = the corrected codeword bit at `rb_pos`.
- R10: A write and a read requested in the same idle cycle: the write is taken and the read is dropped. Read requests made while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write-chunk request (idle only) |
| wr_chunk | input | 64 | Data chunk |
| wr_par | input | 8 | Even parity per byte |
| busy | output | 1 | Writing low or high word |
| par_err | output | 1 | Chunk dropped for parity |
| lane_wr_valid | output | 1 | Lane write bits valid |
| lane_wr_bits | output | 42 | One bit per physical lane |
| rd_req | input | 1 | Read request (idle only) |
| lane_rd_bits | input | 42 | Bits read from the lanes |
| rd_out_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Corrected data word |
| rd_fix | output | 1 | Single error corrected |
| rd_bad | output | 1 | Uncorrectable error |
| map_we | input | 1 | Lane map write |
| map_pos | input | 6 | Codeword index to remap |
| map_lane | input | 6 | New physical lane |
| fail_we | input | 1 | Failed-lane mark write |
| fail_lane | input | 6 | Lane to mark or clear |
| fail_val | input | 1 | 1 = failed, 0 = healthy |
| rb_en | input | 1 | Rebuild output enable |
| rb_pos | input | 6 | Codeword index being rebuilt |
| rb_valid | output | 1 | Rebuild bit valid |
| rb_lane | output | 6 | Lane that receives the bit |
| rb_bit | output | 1 | Corrected bit to write |

## Verification
The hardest case to reach from the ports is a rebuild. The stimulus first moves a codeword index onto a fresh spare lane. It then drives stale data on the old lane and zero on the spare, so that only the remapped lane is wrong. The read must then report a correction, return the right data, and name the spare lane together with the recovered bit. Failed-lane masking is shown by reading the same lanes twice, once before the lane is marked failed and once after, and comparing the correction flag.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
    localparam int DATA_W  = 32;
    localparam int CHK_W   = 6;
    localparam int CW_W    = DATA_W + CHK_W + 1;
    localparam int SPARE_N = 3;
    localparam int LANE_N  = CW_W + SPARE_N;
    localparam int LANE_IW = $clog2(LANE_N);
    localparam int POS_IW  = $clog2(CW_W);
    localparam int CHUNK_W = 2 * DATA_W;
    localparam int PAR_W   = CHUNK_W / 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WR_LO = 2'd1,
        S_WR_HI = 2'd2,
        S_RD    = 2'd3
    } ctrl_state_e;

    function automatic logic is_chk_pos(input int p);
        return (p & (p - 1)) == 0;
    endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import stripe_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CW_W-1:0]   cw
);
    always_comb begin
        logic [CW_W-1:0] body;
        int k;
        body = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                body[p] = data[k];
                k++;
            end
        end
        for (int c = 0; c < CHK_W; c++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> c) & 1) == 1) acc ^= body[p];
            end
            body[1 << c] = acc;
        end
        body[0] = ^body[CW_W-1:1];
        cw = body;
    end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import stripe_pkg::*;
(
    input  logic [CW_W-1:0]   cw_in,
    output logic [CW_W-1:0]   cw_fix,
    output logic [DATA_W-1:0] data,
    output logic              fix,
    output logic              bad
);
    logic [CHK_W-1:0] syn;
    logic             ovr;
    logic [CW_W-1:0]  flip;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw_in[p]) syn ^= CHK_W'(p);
        end
        ovr = ^cw_in;
    end

    always_comb begin
        flip = '0;
        bad  = 1'b0;
        if (ovr) begin
            if (int'(syn) < CW_W) flip[syn] = 1'b1;
            else                  bad       = 1'b1;
        end else if (syn != '0) begin
            bad = 1'b1;
        end
        fix    = |flip;
        cw_fix = cw_in ^ flip;
    end

    always_comb begin
        int k;
        k = 0;
        data = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                data[k] = cw_fix[p];
                k++;
            end
        end
        if (bad) data = '0;
    end
endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
    import stripe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_we,
    input  logic [POS_IW-1:0]  map_pos,
    input  logic [LANE_IW-1:0] map_lane,
    input  logic               fail_we,
    input  logic [LANE_IW-1:0] fail_lane,
    input  logic               fail_val,
    input  logic [CW_W-1:0]    cw_out,
    output logic [LANE_N-1:0]  lanes_out,
    input  logic [LANE_N-1:0]  lanes_in,
    output logic [CW_W-1:0]    cw_in,
    input  logic [POS_IW-1:0]  query_pos,
    output logic [LANE_IW-1:0] query_lane
);
    logic [LANE_IW-1:0] map_q [CW_W];
    logic [LANE_N-1:0]  fail_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < CW_W; p++) map_q[p] <= LANE_IW'(p);
            fail_q <= '0;
        end else begin
            if (map_we && int'(map_pos) < CW_W && int'(map_lane) < LANE_N)
                map_q[map_pos] <= map_lane;
            if (fail_we && int'(fail_lane) < LANE_N)
                fail_q[fail_lane] <= fail_val;
        end
    end

    generate
        for (genvar l = 0; l < LANE_N; l++) begin : g_scatter
            always_comb begin
                lanes_out[l] = 1'b0;
                for (int p = 0; p < CW_W; p++) begin
                    if (map_q[p] == LANE_IW'(l)) lanes_out[l] = lanes_out[l] | cw_out[p];
                end
            end
        end
        for (genvar p = 0; p < CW_W; p++) begin : g_gather
            assign cw_in[p] = lanes_in[map_q[p]] & ~fail_q[map_q[p]];
            // R4: every stored lane index stays inside the physical lane range
            p_map_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
                int'(map_q[p]) < LANE_N);
        end
    endgenerate

    assign query_lane = (int'(query_pos) < CW_W) ? map_q[query_pos] : '0;
endmodule

// File: rtl/stripe_ecc_ctrl.sv
module stripe_ecc_ctrl
    import stripe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [CHUNK_W-1:0] wr_chunk,
    input  logic [PAR_W-1:0]   wr_par,
    output logic               busy,
    output logic               par_err,
    output logic               lane_wr_valid,
    output logic [LANE_N-1:0]  lane_wr_bits,
    input  logic               rd_req,
    input  logic [LANE_N-1:0]  lane_rd_bits,
    output logic               rd_out_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_fix,
    output logic               rd_bad,
    input  logic               map_we,
    input  logic [POS_IW-1:0]  map_pos,
    input  logic [LANE_IW-1:0] map_lane,
    input  logic               fail_we,
    input  logic [LANE_IW-1:0] fail_lane,
    input  logic               fail_val,
    input  logic               rb_en,
    input  logic [POS_IW-1:0]  rb_pos,
    output logic               rb_valid,
    output logic [LANE_IW-1:0] rb_lane,
    output logic               rb_bit
);
    ctrl_state_e        state, state_nx;
    logic [CHUNK_W-1:0] chunk_q;
    logic [CW_W-1:0]    rd_cw_q;
    logic               par_err_q;
    logic               par_ok;
    logic [DATA_W-1:0]  enc_data;
    logic [CW_W-1:0]    enc_cw;
    logic [LANE_N-1:0]  scat_lanes;
    logic [CW_W-1:0]    gath_cw;
    logic [CW_W-1:0]    dec_cw;
    logic [DATA_W-1:0]  dec_data;
    logic               dec_fix, dec_bad;
    logic [LANE_IW-1:0] q_lane;

    always_comb begin
        par_ok = 1'b1;
        for (int b = 0; b < PAR_W; b++) begin
            if ((^wr_chunk[b*8 +: 8]) != wr_par[b]) par_ok = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (wr_req && par_ok)    state_nx = S_WR_LO;
                else if (rd_req && !wr_req) state_nx = S_RD;
            end
            S_WR_LO: state_nx = S_WR_HI;
            S_WR_HI: state_nx = S_IDLE;
            S_RD:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_q   <= '0;
            rd_cw_q   <= '0;
            par_err_q <= 1'b0;
        end else begin
            par_err_q <= (state == S_IDLE) && wr_req && !par_ok;
            if (state == S_IDLE && wr_req && par_ok) chunk_q <= wr_chunk;
            if (state == S_IDLE && rd_req && !wr_req) rd_cw_q <= gath_cw;
        end
    end

    ecc_enc i_enc (.data(enc_data), .cw(enc_cw));

    ecc_dec i_dec (
        .cw_in (rd_cw_q),
        .cw_fix(dec_cw),
        .data  (dec_data),
        .fix   (dec_fix),
        .bad   (dec_bad)
    );

    lane_xbar i_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_we    (map_we),
        .map_pos   (map_pos),
        .map_lane  (map_lane),
        .fail_we   (fail_we),
        .fail_lane (fail_lane),
        .fail_val  (fail_val),
        .cw_out    (enc_cw),
        .lanes_out (scat_lanes),
        .lanes_in  (lane_rd_bits),
        .cw_in     (gath_cw),
        .query_pos (rb_pos),
        .query_lane(q_lane)
    );

    // outputs
    always_comb begin
        busy          = 1'b0;
        lane_wr_valid = 1'b0;
        rd_out_valid  = 1'b0;
        enc_data      = chunk_q[DATA_W-1:0];
        unique case (state)
            S_IDLE:  ;
            S_WR_LO: begin
                busy          = 1'b1;
                lane_wr_valid = 1'b1;
            end
            S_WR_HI: begin
                busy          = 1'b1;
                lane_wr_valid = 1'b1;
                enc_data      = chunk_q[CHUNK_W-1:DATA_W];
            end
            S_RD:    rd_out_valid = 1'b1;
        endcase
        par_err      = par_err_q;
        lane_wr_bits = lane_wr_valid ? scat_lanes : '0;
        rd_data      = rd_out_valid ? dec_data : '0;
        rd_fix       = rd_out_valid & dec_fix;
        rd_bad       = rd_out_valid & dec_bad;
        rb_valid     = rd_out_valid & rb_en;
        rb_lane      = rb_valid ? q_lane : '0;
        rb_bit       = rb_valid && (int'(rb_pos) < CW_W) ? dec_cw[rb_pos] : 1'b0;
    end

    // R2: the low word is always followed by the high word
    p_lo_then_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_LO) |=> (state == S_WR_HI));
    // R1: a dropped chunk is never written
    p_parerr_nowrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> !lane_wr_valid);
    // R5: a read result lasts a single cycle
    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_valid |=> !rd_out_valid);
    // R7: correction and uncorrectable flags never coincide
    p_fix_bad_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_fix && rd_bad));
    // R9: rebuild output only accompanies a read result
    p_rb_with_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> rd_out_valid);
    // R10: no read result while a write is in progress
    p_busy_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rd_out_valid);
endmodule

// File: tb/test_stripe_ecc_ctrl.sv
`timescale 1ns/100ps
module test_stripe_ecc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_req;
    logic [63:0] wr_chunk;
    logic [7:0]  wr_par;
    logic        busy, par_err, lane_wr_valid;
    logic [41:0] lane_wr_bits;
    logic        rd_req;
    logic [41:0] lane_rd_bits;
    logic        rd_out_valid;
    logic [31:0] rd_data;
    logic        rd_fix, rd_bad;
    logic        map_we;
    logic [5:0]  map_pos, map_lane;
    logic        fail_we;
    logic [5:0]  fail_lane;
    logic        fail_val;
    logic        rb_en;
    logic [5:0]  rb_pos;
    logic        rb_valid;
    logic [5:0]  rb_lane;
    logic        rb_bit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stripe_ecc_ctrl i_stripe_ecc_ctrl (.*);

    // data word, first flipped index, second flipped index (63 = none)
    localparam logic [43:0] TBL [10] = '{
        {32'h0000_0000, 6'd63, 6'd63},
        {32'hFFFF_FFFF, 6'd63, 6'd63},
        {32'hA5A5_5A5A, 6'd0,  6'd63},
        {32'h1234_5678, 6'd3,  6'd63},
        {32'hDEAD_BEEF, 6'd32, 6'd63},
        {32'h8000_0001, 6'd38, 6'd63},
        {32'h0000_0001, 6'd16, 6'd63},
        {32'hCAFE_F00D, 6'd1,  6'd2},
        {32'h0F0F_0F0F, 6'd0,  6'd38},
        {32'h1357_9BDF, 6'd7,  6'd20}
    };

    function automatic logic [38:0] ref_enc(input logic [31:0] d);
        logic [38:0] w;
        logic [5:0]  s;
        int j;
        w = '0; s = '0; j = 0;
        for (int i = 3; i < 39; i++) begin
            if (i != 4 && i != 8 && i != 16 && i != 32) begin
                w[i] = d[j];
                if (d[j]) s ^= 6'(i);
                j++;
            end
        end
        for (int c = 0; c < 6; c++) w[1 << c] = s[c];
        w[0] = ^w[38:1];
        return w;
    endfunction

    function automatic logic [7:0] ref_par(input logic [63:0] c);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = ^c[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_check(input logic [63:0] c, input logic [41:0] lo_exp,
                               input logic [41:0] hi_exp, input string req);
        wr_req = 1'b1; wr_chunk = c; wr_par = ref_par(c);
        tick();
        wr_req = 1'b0;
        chk({req, " lo valid"}, 64'(lane_wr_valid & busy), 64'd1);
        chk({req, " lo lanes"}, 64'(lane_wr_bits), 64'(lo_exp));
        tick();
        chk({req, " hi valid"}, 64'(lane_wr_valid & busy), 64'd1);
        chk({req, " hi lanes"}, 64'(lane_wr_bits), 64'(hi_exp));
        tick();
        chk({req, " done"}, 64'(busy | lane_wr_valid), 64'd0);
    endtask

    task automatic read_lanes(input logic [41:0] lanes);
        rd_req = 1'b1; lane_rd_bits = lanes;
        tick();
        rd_req = 1'b0; lane_rd_bits = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [38:0] cw, cw2;
        logic [41:0] lanes;
        rst_n = 1'b0; wr_req = 0; wr_chunk = '0; wr_par = '0; rd_req = 0;
        lane_rd_bits = '0; map_we = 0; map_pos = '0; map_lane = '0;
        fail_we = 0; fail_lane = '0; fail_val = 0; rb_en = 0; rb_pos = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R2 reset state
        chk("R2 reset", 64'({busy, lane_wr_valid, par_err, rd_out_valid}), 64'd0);

        // R2 R3 R4: identity map, spares zero
        cw  = ref_enc(32'h89AB_CDEF);
        cw2 = ref_enc(32'h0123_4567);
        write_check(64'h0123_4567_89AB_CDEF, {3'b0, cw}, {3'b0, cw2}, "R2 R3 R4 write");
        cw  = ref_enc(32'h0000_0001);
        cw2 = ref_enc(32'h8000_0000);
        write_check(64'h8000_0000_0000_0001, {3'b0, cw}, {3'b0, cw2}, "R3 layout");

        // R1 bad parity
        wr_req = 1'b1; wr_chunk = 64'h1111_2222_3333_4444;
        wr_par = ref_par(wr_chunk) ^ 8'h04;
        tick();
        wr_req = 1'b0;
        chk("R1 par_err", 64'(par_err), 64'd1);
        chk("R1 no write", 64'(lane_wr_valid | busy), 64'd0);
        tick();
        chk("R1 par_err clears", 64'(par_err | lane_wr_valid), 64'd0);

        // R5 R6 R7 table of reads
        for (int t = 0; t < 10; t++) begin
            logic [31:0] d;
            logic [5:0]  e1, e2;
            int nerr;
            d = TBL[t][43:12]; e1 = TBL[t][11:6]; e2 = TBL[t][5:0];
            lanes = {3'b0, ref_enc(d)};
            nerr = 0;
            if (e1 != 6'd63) begin lanes[e1] = ~lanes[e1]; nerr++; end
            if (e2 != 6'd63) begin lanes[e2] = ~lanes[e2]; nerr++; end
            read_lanes(lanes);
            chk("R5 rd valid", 64'(rd_out_valid), 64'd1);
            if (nerr == 0) begin
                chk("R5 clean data", 64'(rd_data), 64'(d));
                chk("R5 clean flags", 64'({rd_fix, rd_bad}), 64'd0);
            end else if (nerr == 1) begin
                chk("R6 corrected data", 64'(rd_data), 64'(d));
                chk("R6 flags", 64'({rd_fix, rd_bad}), 64'b10);
            end else begin
                chk("R7 data zero", 64'(rd_data), 64'd0);
                chk("R7 flags", 64'({rd_fix, rd_bad}), 64'b01);
            end
            tick();
            chk("R5 pulse", 64'(rd_out_valid), 64'd0);
        end

        // R4 remap index 5 to spare 40; out-of-range map write ignored
        map_we = 1'b1; map_pos = 6'd5; map_lane = 6'd40;
        tick();
        map_pos = 6'd6; map_lane = 6'd50;
        tick();
        map_we = 1'b0;
        cw  = ref_enc(32'h0000_0002);
        cw2 = ref_enc(32'hFFFF_FFFD);
        begin
            logic [41:0] lo, hi;
            lo = {3'b0, cw};  lo[5] = 1'b0; lo[40] = cw[5];
            hi = {3'b0, cw2}; hi[5] = 1'b0; hi[40] = cw2[5];
            write_check(64'hFFFF_FFFD_0000_0002, lo, hi, "R4 remap");
        end

        // R9 rebuild: spare 40 fresh (0), stale data on old lane 5
        lanes = {3'b0, cw}; lanes[40] = 1'b0; lanes[5] = ~cw[5];
        rb_en = 1'b1; rb_pos = 6'd5;
        read_lanes(lanes);
        chk("R9 data", 64'(rd_data), 64'h2);
        chk("R9 fix", 64'({rd_fix, rd_bad}), 64'b10);
        chk("R9 rb", 64'({rb_valid, rb_lane, rb_bit}), 64'({1'b1, 6'd40, 1'b1}));
        rb_en = 1'b0;
        tick();

        // R8 failed lane: same read before and after marking lane 12
        cw = ref_enc(32'h0000_0080);
        lanes = {3'b0, cw}; lanes[5] = 1'b0; lanes[40] = cw[5];
        read_lanes(lanes);
        chk("R8 healthy flags", 64'({rd_fix, rd_bad}), 64'd0);
        fail_we = 1'b1; fail_lane = 6'd12; fail_val = 1'b1;
        tick();
        fail_we = 1'b0;
        read_lanes(lanes);
        chk("R8 failed data", 64'(rd_data), 64'h80);
        chk("R8 failed flags", 64'({rd_fix, rd_bad}), 64'b10);
        tick();

        // R10 write wins; reads during busy ignored
        wr_req = 1'b1; wr_chunk = 64'h5555_AAAA_0F0F_F0F0; wr_par = ref_par(wr_chunk);
        rd_req = 1'b1; lane_rd_bits = lanes;
        tick();
        wr_req = 1'b0;
        chk("R10 write taken", 64'({lane_wr_valid, rd_out_valid}), 64'b10);
        tick();
        chk("R10 busy read ignored", 64'({lane_wr_valid, rd_out_valid}), 64'b10);
        rd_req = 1'b0;
        tick();
        chk("R10 no late read", 64'({busy, rd_out_valid}), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule